// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block sits on the host side of a byte-wide parallel peripheral link. It occupies a small register window. In that window the host reads and writes a data latch, a control latch and a status view. It can also start enhanced-mode address cycles at offset 3 and data cycles at offset 4. Each enhanced cycle is carried out as a request/acknowledge handshake on a byte bus toward the peripheral. Offset 4 also takes 2- and 4-byte accesses, which are broken into byte cycles sent least significant byte first.

An enhanced cycle is started only if the stored control latch holds the pattern for the requested direction. For writes, only the init bit may be set among the five bits under mask 0x2F. For reads, the direction and init bits must be set. If the pattern is wrong, the access is dropped without any handshake. If a peripheral fails to acknowledge within a parameterised number of clocks, the remaining bytes are abandoned and a sticky timeout flag is set. That flag appears in status bit 0, and the host clears it by writing status with bit 0 set. A second window, selected by a high address bit, is inert: writes to it do nothing and reads from it return 0xFF.

Every accepted host access ends with a single-cycle ready pulse. The busy output is high from the cycle after acceptance through the ready cycle.

Top module: `epp_ctrl_top`

## Requirements
- R1: After reset the data latch reads 0xFF, the control latch reads 0xCC, the timeout flag is 0, and no peripheral request is active.
- R2: A write at offset 3 or 4 produces peripheral byte cycles only when (control & 0x2F) == 0x04. Otherwise no request is raised and the access still completes.
- R3: An offset-3 cycle drives per_addr_cyc=1 and an offset-4 cycle drives per_addr_cyc=0. On a write, the byte is presented on per_wdata and per_wr=1.
- R4: A read at offset 3 or 4 produces byte cycles only when (control & 0x2F) == 0x24. Otherwise it returns 0xFF in every accessed byte and 0 above them, with no request.
- R5: At offset 4, host_size selects the access width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Byte k travels in cycle k, taken from or placed in host_data bits 8k+7:8k. Offset 3 is always a single byte.
- R6: Each byte cycle holds per_req until per_ack is sampled high, for at most TMO_CYC cycles. An acknowledge in the last allowed cycle still counts as success.
- R7: A byte cycle with no acknowledge in time sets the timeout flag and skips the remaining bytes. The access still ends with ready, and read bytes that were never transferred read 0xFF.
- R8: A status read (offset 1) returns per_stat bits 7:1 with the timeout flag in bit 0.
- R9: A status write with bit 0 set clears the timeout flag. With bit 0 clear it has no effect. Successful cycles never clear the flag.
- R10: When address bit ECP_BIT is set, writes change nothing and reads return 0xFF. Reads of offsets 5 to 7 also return 0xFF.
- R11: Offset 0 stores wdata[7:0] and offset 2 stores wdata[7:0] OR 0xC0. line_upd pulses for one cycle only when the stored value changes.
- R12: Every accepted access yields exactly one single-cycle host_ready. busy is high from the cycle after acceptance through ready. Requests arriving while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Single-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Window address; bits 2:0 are the offset, bit ECP_BIT selects the inert window |
| host_size | input | 2 | Access width code for offset 4 |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | Access completion pulse |
| busy | output | 1 | Access in progress |
| per_req | output | 1 | Peripheral byte-cycle request |
| per_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| per_wr | output | 1 | 1 = byte toward peripheral |
| per_wdata | output | 8 | Byte toward peripheral |
| per_rdata | input | 8 | Byte from peripheral, taken with per_ack |
| per_ack | input | 1 | Peripheral acknowledge |
| per_stat | input | 8 | Peripheral status lines |
| line_data | output | 8 | Stored data latch |
| line_ctrl | output | 8 | Stored control latch |
| line_upd | output | 1 | Pulse when a latch value changed |

## Verification
On every cycle, the checker enforces the following: the control pattern that must hold while a request is raised in each direction, the cap on request length, single-cycle ready, and that busy covers every request. It also ties falls of the timeout flag to a status write, ties rises of the flag to a completing access, and ties latch-update pulses to real value changes. Some behaviours can be shown only by the bench scenarios: little-endian byte order, assembly of read data, the exact boundary cycle of the acknowledge window, and the number of bytes that survive an abort at each byte position. The same holds for the inert window, the all-ones returns of blocked reads, and the dropping of requests made while busy.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_GAP  = 2'd2,
        S_FIN  = 2'd3
    } seq_e;

    localparam logic [2:0] OFF_DATA  = 3'd0;
    localparam logic [2:0] OFF_STAT  = 3'd1;
    localparam logic [2:0] OFF_CTRL  = 3'd2;
    localparam logic [2:0] OFF_EADDR = 3'd3;
    localparam logic [2:0] OFF_EDATA = 3'd4;

    localparam logic [7:0] CTRL_FORCE = 8'hC0;
    localparam logic [7:0] CTRL_RST   = 8'hCC;
    localparam logic [7:0] GATE_MASK  = 8'h2F;
    localparam logic [7:0] GATE_WR    = 8'h04;
    localparam logic [7:0] GATE_RD    = 8'h24;

endpackage

// File: rtl/epp_gate.sv
module epp_gate
    import epp_pkg::*;
(
    input  logic [7:0] ctrl,
    input  logic       is_rd,
    output logic       ok
);
    logic [7:0] want;

    always_comb begin
        want = is_rd ? GATE_RD : GATE_WR;
        ok   = ((ctrl & GATE_MASK) == want);
    end
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = run ? cnt_q + CW'(1) : '0;
        expire = run && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/epp_ctrl_top.sv
module epp_ctrl_top
    import epp_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int ECP_BIT = 10,
    parameter int TMO_CYC = 16,
    parameter int HOST_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ready,
    output logic              busy,
    output logic              per_req,
    output logic              per_addr_cyc,
    output logic              per_wr,
    output logic [7:0]        per_wdata,
    input  logic [7:0]        per_rdata,
    input  logic              per_ack,
    input  logic [7:0]        per_stat,
    output logic [7:0]        line_data,
    output logic [7:0]        line_ctrl,
    output logic              line_upd
);
    localparam int NBYTE = HOST_W / 8;
    localparam int IDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;

    typedef struct packed {
        seq_e              st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic              is_rd;
        logic              is_addr;
        logic [HOST_W-1:0] wbuf;
        logic [HOST_W-1:0] rbuf;
        logic [7:0]        data;
        logic [7:0]        ctrl;
        logic              tmo;
        logic              upd;
    } regs_t;

    localparam regs_t RST = '{
        st: S_IDLE, idx: '0, last: '0, is_rd: 1'b0, is_addr: 1'b0,
        wbuf: '0, rbuf: '0, data: 8'hFF, ctrl: CTRL_RST, tmo: 1'b0, upd: 1'b0
    };

    regs_t r_d, r_q;

    logic             gate_ok;
    logic             expire;
    logic [2:0]       off;
    logic             ecp;
    logic             acc;
    logic [IDX_W-1:0] last_c;
    logic [7:0]       ctrl_new;
    logic             tmo_flag;

    epp_gate u_gate (
        .ctrl  (r_q.ctrl),
        .is_rd (!host_we),
        .ok    (gate_ok)
    );

    epp_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.st == S_REQ),
        .expire (expire)
    );

    always_comb begin
        off      = host_addr[2:0];
        ecp      = host_addr[ECP_BIT];
        acc      = host_req && (r_q.st == S_IDLE);
        ctrl_new = host_wdata[7:0] | CTRL_FORCE;
        if (off != OFF_EDATA)      last_c = '0;
        else if (host_size == 2'd0) last_c = '0;
        else if (host_size == 2'd1) last_c = IDX_W'(1);
        else                        last_c = IDX_W'(NBYTE - 1);
    end

    always_comb begin
        r_d     = r_q;
        r_d.upd = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (acc) begin
                    r_d.st   = S_FIN;
                    r_d.rbuf = '0;
                    if (ecp) begin
                        if (!host_we) r_d.rbuf[7:0] = 8'hFF;
                    end else begin
                        case (off)
                            OFF_DATA: begin
                                if (host_we) begin
                                    if (host_wdata[7:0] != r_q.data) begin
                                        r_d.data = host_wdata[7:0];
                                        r_d.upd  = 1'b1;
                                    end
                                end else begin
                                    r_d.rbuf[7:0] = r_q.data;
                                end
                            end
                            OFF_STAT: begin
                                if (host_we) begin
                                    if (host_wdata[0]) r_d.tmo = 1'b0;
                                end else begin
                                    r_d.rbuf[7:0] = {per_stat[7:1], r_q.tmo};
                                end
                            end
                            OFF_CTRL: begin
                                if (host_we) begin
                                    if (ctrl_new != r_q.ctrl) begin
                                        r_d.ctrl = ctrl_new;
                                        r_d.upd  = 1'b1;
                                    end
                                end else begin
                                    r_d.rbuf[7:0] = r_q.ctrl;
                                end
                            end
                            OFF_EADDR, OFF_EDATA: begin
                                r_d.idx     = '0;
                                r_d.last    = last_c;
                                r_d.is_rd   = !host_we;
                                r_d.is_addr = (off == OFF_EADDR);
                                r_d.wbuf    = HOST_W'(host_wdata);
                                if (!host_we) begin
                                    for (int i = 0; i < NBYTE; i++) begin
                                        r_d.rbuf[i*8 +: 8] = (i <= int'(last_c)) ? 8'hFF : 8'h00;
                                    end
                                end
                                if (gate_ok) r_d.st = S_REQ;
                            end
                            default: begin
                                if (!host_we) r_d.rbuf[7:0] = 8'hFF;
                            end
                        endcase
                    end
                end
            end
            S_REQ: begin
                if (per_ack) begin
                    if (r_q.is_rd) r_d.rbuf[{r_q.idx, 3'b000} +: 8] = per_rdata;
                    if (r_q.idx == r_q.last) begin
                        r_d.st = S_FIN;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                        r_d.st  = S_GAP;
                    end
                end else if (expire) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = S_FIN;
                end
            end
            S_GAP:   r_d.st = S_REQ;
            S_FIN:   r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    always_comb begin
        host_rdata   = 32'(r_q.rbuf);
        host_ready   = (r_q.st == S_FIN);
        busy         = (r_q.st != S_IDLE);
        per_req      = (r_q.st == S_REQ);
        per_addr_cyc = r_q.is_addr;
        per_wr       = !r_q.is_rd;
        per_wdata    = r_q.wbuf[{r_q.idx, 3'b000} +: 8];
        line_data    = r_q.data;
        line_ctrl    = r_q.ctrl;
        line_upd     = r_q.upd;
        tmo_flag     = r_q.tmo;
    end
endmodule

// File: rtl/epp_ctrl_chk.sv
module epp_ctrl_chk #(
    parameter int ADDR_W  = 11,
    parameter int ECP_BIT = 10,
    parameter int TMO_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [31:0]       host_wdata,
    input logic              host_ready,
    input logic              busy,
    input logic              per_req,
    input logic              per_wr,
    input logic [7:0]        line_data,
    input logic [7:0]        line_ctrl,
    input logic              line_upd,
    input logic              tmo_flag
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_cnt <= '0;
        else if (!per_req)    run_cnt <= '0;
        else if (run_cnt != 16'hFFFF) run_cnt <= run_cnt + 16'd1;
    end

    p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> busy);

    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    p_wr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && per_wr) |-> ((line_ctrl & 8'h2F) == 8'h04));

    p_rd_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !per_wr) |-> ((line_ctrl & 8'h2F) == 8'h24));

    p_req_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> (run_cnt < 16'(TMO_CYC)));

    p_tmo_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_flag) |-> $past(host_req && host_we && !busy &&
                                  host_addr[2:0] == 3'd1 &&
                                  !host_addr[ECP_BIT] && host_wdata[0]));

    p_tmo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> host_ready);

    p_upd_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_upd |-> ((line_data != $past(line_data)) || (line_ctrl != $past(line_ctrl))));
endmodule

bind epp_ctrl_top epp_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .ECP_BIT (ECP_BIT),
    .TMO_CYC (TMO_CYC)
) chk_i (.*);

// File: tb/epp_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module epp_ctrl_top_tb_top;
    localparam int TMO = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready, busy, per_req, per_addr_cyc, per_wr, line_upd;
    logic [7:0]  per_wdata, line_data, line_ctrl;
    logic [7:0]  per_rdata = '0;
    logic        per_ack = 1'b0;
    logic [7:0]  per_stat = 8'hFF;

    int total = 0;
    int bad = 0;

    int delay = 0;
    int fail_from = 99;
    int reqcyc = 0;
    int byte_no = 0;
    int nlog = 0;
    int upd_cnt = 0;
    logic [7:0] wlog [0:63];
    logic       alog [0:63];
    logic       dlog [0:63];

    always #2.5 clk = ~clk;

    epp_ctrl_top #(.TMO_CYC(TMO)) dut_i (
        .clk, .rst_n, .host_req, .host_we, .host_addr, .host_size, .host_wdata,
        .host_rdata, .host_ready, .busy, .per_req, .per_addr_cyc, .per_wr,
        .per_wdata, .per_rdata, .per_ack, .per_stat, .line_data, .line_ctrl,
        .line_upd
    );

    // peripheral model, acts on falling edges
    always @(negedge clk) begin
        if (!busy) byte_no = 0;
        if (per_req) reqcyc = reqcyc + 1;
        else         reqcyc = 0;
        if (per_req && byte_no < fail_from && reqcyc > delay) begin
            per_ack   = 1'b1;
            per_rdata = 8'hA0 + 8'(byte_no);
            wlog[nlog % 64] = per_wdata;
            alog[nlog % 64] = per_addr_cyc;
            dlog[nlog % 64] = per_wr;
            nlog    = nlog + 1;
            byte_no = byte_no + 1;
        end else begin
            per_ack = 1'b0;
        end
        if (line_upd) upd_cnt = upd_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [10:0] addr, input logic [1:0] size,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_size = size; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R12 busy after accept", 32'(busy), 32'd1);
        while (!host_ready && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = host_rdata;
        @(negedge clk);
        chk(host_ready == 1'b0 && busy == 1'b0, "R12 single ready", 32'(host_ready), 32'd0);
    endtask

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd, exp;
        int lat, base, u0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(per_req == 1'b0, "R1 no request", 32'(per_req), 32'd0);
        access(0, 11'd2, 0, 0, rd, lat); chk(rd == 32'hCC, "R1 ctrl reset", rd, 32'hCC);
        access(0, 11'd0, 0, 0, rd, lat); chk(rd == 32'hFF, "R1 data reset", rd, 32'hFF);
        access(0, 11'd1, 0, 0, rd, lat); chk(rd == 32'hFE, "R1 R8 status tmo clear", rd, 32'hFE);

        // R2 / R4 blocked with reset control
        base = nlog;
        access(1, 11'd4, 0, 32'h55, rd, lat); chk(nlog == base, "R2 write blocked", nlog - base, 0);
        access(0, 11'd4, 1, 0, rd, lat);
        chk(rd == 32'h0000FFFF && nlog == base, "R4 read blocked", rd, 32'h0000FFFF);

        // R11 latch writes
        u0 = upd_cnt;
        access(1, 11'd2, 0, 32'h04, rd, lat); chk(upd_cnt == u0 + 1, "R11 ctrl change pulse", upd_cnt - u0, 1);
        access(0, 11'd2, 0, 0, rd, lat); chk(rd == 32'hC4, "R11 ctrl forced bits", rd, 32'hC4);
        access(1, 11'd2, 0, 32'hC4, rd, lat); chk(upd_cnt == u0 + 1, "R11 equal ctrl no pulse", upd_cnt - u0, 1);
        access(1, 11'd0, 0, 32'hFF, rd, lat); chk(upd_cnt == u0 + 1, "R11 equal data no pulse", upd_cnt - u0, 1);
        access(1, 11'd0, 0, 32'h3C, rd, lat); chk(upd_cnt == u0 + 2, "R11 data change pulse", upd_cnt - u0, 2);
        access(0, 11'd0, 0, 0, rd, lat); chk(rd == 32'h3C, "R11 data readback", rd, 32'h3C);

        // R3 address cycle write
        base = nlog;
        access(1, 11'd3, 2'd3, 32'h1122339A, rd, lat);
        chk(nlog == base + 1, "R3 R5 addr cycle one byte", nlog - base, 1);
        chk(wlog[base % 64] == 8'h9A && alog[base % 64] == 1'b1 && dlog[base % 64] == 1'b1,
            "R3 addr cycle byte", {wlog[base % 64], 7'd0, alog[base % 64]}, 32'h9A01);

        // R5 write widths
        for (int sz = 0; sz < 4; sz++) begin
            logic [31:0] wd;
            wd = 32'h44332211 + 32'(sz * 32'h01010101);
            base = nlog;
            access(1, 11'd4, 2'(sz), wd, rd, lat);
            chk(nlog - base == nbytes(sz), "R5 write byte count", nlog - base, nbytes(sz));
            for (int i = 0; i < nbytes(sz); i++)
                chk(wlog[(base + i) % 64] == wd[i*8 +: 8] && alog[(base + i) % 64] == 1'b0,
                    "R3 R5 write byte order", wlog[(base + i) % 64], wd[i*8 +: 8]);
        end

        // R4 read blocked in write pattern
        base = nlog;
        access(0, 11'd4, 2'd2, 0, rd, lat);
        chk(rd == 32'hFFFFFFFF && nlog == base, "R4 read blocked write pattern", rd, 32'hFFFFFFFF);

        // switch to read pattern
        access(1, 11'd2, 0, 32'h24, rd, lat);
        base = nlog;
        access(1, 11'd4, 0, 32'h77, rd, lat); chk(nlog == base, "R2 write blocked read pattern", nlog - base, 0);
        for (int sz = 0; sz < 4; sz++) begin
            exp = '0;
            for (int i = 0; i < nbytes(sz); i++) exp[i*8 +: 8] = 8'hA0 + 8'(i);
            access(0, 11'd4, 2'(sz), 0, rd, lat);
            chk(rd == exp, "R4 R5 read assembly", rd, exp);
        end
        access(0, 11'd3, 0, 0, rd, lat); chk(rd == 32'hA0, "R3 R4 addr read", rd, 32'hA0);

        // R6 acknowledge window sweep
        for (int d = 0; d <= TMO + 2; d++) begin
            access(1, 11'd1, 0, 32'h01, rd, lat);
            delay = d;
            access(0, 11'd4, 0, 0, rd, lat);
            delay = 0;
            chk(lat == ((d < TMO) ? d + 2 : TMO + 1), "R6 cycle length", lat, (d < TMO) ? d + 2 : TMO + 1);
            chk(rd == ((d < TMO) ? 32'hA0 : 32'hFF), "R6 R7 read data", rd, (d < TMO) ? 32'hA0 : 32'hFF);
            access(0, 11'd1, 0, 0, rd, lat);
            chk(rd[0] == (d >= TMO), "R6 R7 timeout flag", rd[0], 32'(d >= TMO));
        end

        // R7 abort at each byte, read and write
        for (int f = 0; f <= 4; f++) begin
            access(1, 11'd1, 0, 32'h01, rd, lat);
            fail_from = f;
            base = nlog;
            access(0, 11'd4, 2'd2, 0, rd, lat);
            exp = '0;
            for (int i = 0; i < 4; i++) exp[i*8 +: 8] = (i < f) ? 8'hA0 + 8'(i) : 8'hFF;
            chk(rd == exp, "R7 partial read", rd, exp);
            chk(nlog - base == ((f < 4) ? f : 4), "R7 bytes before abort", nlog - base, (f < 4) ? f : 4);
            fail_from = 99;
            access(0, 11'd1, 0, 0, rd, lat);
            chk(rd[0] == (f < 4), "R7 flag after abort", rd[0], 32'(f < 4));
        end
        access(1, 11'd2, 0, 32'h04, rd, lat);
        for (int f = 0; f <= 4; f++) begin
            access(1, 11'd1, 0, 32'h01, rd, lat);
            fail_from = f;
            base = nlog;
            access(1, 11'd4, 2'd2, 32'hDDCCBBAA, rd, lat);
            fail_from = 99;
            chk(nlog - base == ((f < 4) ? f : 4), "R7 write bytes before abort", nlog - base, (f < 4) ? f : 4);
        end

        // R9 sticky flag (currently clear after f=4); force a timeout
        fail_from = 0;
        access(1, 11'd4, 0, 32'h12, rd, lat);
        fail_from = 99;
        access(1, 11'd1, 0, 32'hFE, rd, lat);
        access(0, 11'd1, 0, 0, rd, lat); chk(rd[0] == 1'b1, "R9 bit0 clear write no effect", rd[0], 1);
        access(1, 11'd4, 0, 32'h12, rd, lat);
        access(0, 11'd1, 0, 0, rd, lat); chk(rd[0] == 1'b1, "R9 success keeps flag", rd[0], 1);

        // R8 status composition
        per_stat = 8'h00;
        access(0, 11'd1, 0, 0, rd, lat); chk(rd == 32'h01, "R8 status with flag", rd, 32'h01);
        access(1, 11'd1, 0, 32'h01, rd, lat);
        per_stat = 8'hA5;
        access(0, 11'd1, 0, 0, rd, lat); chk(rd == 32'hA4, "R8 R9 status cleared flag", rd, 32'hA4);

        // R10 inert window and unused offsets
        u0 = upd_cnt;
        access(1, 11'h402, 0, 32'h24, rd, lat);
        access(0, 11'd2, 0, 0, rd, lat);
        chk(rd == 32'hC4 && upd_cnt == u0, "R10 inert write", rd, 32'hC4);
        access(0, 11'h400, 0, 0, rd, lat); chk(rd == 32'hFF, "R10 inert read", rd, 32'hFF);
        base = nlog;
        access(1, 11'h404, 0, 32'h5A, rd, lat); chk(nlog == base, "R10 inert no cycle", nlog - base, 0);
        for (int o = 5; o < 8; o++) begin
            access(0, 11'(o), 0, 0, rd, lat); chk(rd == 32'hFF, "R10 unused offset", rd, 32'hFF);
        end

        // R12 request while busy ignored
        access(1, 11'd2, 0, 32'h24, rd, lat);
        delay = 2;
        base = nlog;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 11'd4; host_size = 2'd2;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 11'd2; host_wdata = 32'h00;
        @(negedge clk);
        host_req = 1'b0;
        for (int k = 0; k < 100 && !host_ready; k++) @(negedge clk);
        rd = host_rdata;
        @(negedge clk);
        delay = 0;
        chk(rd == 32'hA3A2A1A0 && nlog - base == 4, "R12 busy access intact", rd, 32'hA3A2A1A0);
        access(0, 11'd2, 0, 0, rd, lat); chk(rd == 32'hE4, "R12 request while busy ignored", rd, 32'hE4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule